// File: doc/BRIEF.md
# Handshaked Control-Register Bus Master

This block lets on-chip logic read and write the 16-bit control registers of a peripheral that only offers a narrow, fully interlocked register port. That port has one shared 16-bit value bus toward the peripheral, four strobes (address capture, data capture, read, write), a 16-bit return bus and a single ack line. The master turns one host command into the fixed chain of strobe phases that the port expects.

Every phase follows the same steps. The value is first presented with no strobe for a setup interval. The strobe is then raised until ack is seen high, dropped, and the phase ends when ack is seen low. A write is address capture, data capture, then the write strobe. A read is address capture, then the read strobe with a zero value bus, and the return bus is sampled while ack is high. A read-modify-write runs a read, merges a mask and value into the result, then runs a full write. A cycle-count timeout guards each ack wait on its own. On expiry the command is abandoned and the port is left idle.

Top module: `cr_bus_master`

## Requirements
- R1: After reset, busy_o, done_o, err_o, all four strobes and bus_val_o are low.
- R2: Before each strobe rises, bus_val_o carries the phase value with no strobe for at least SETUP_CYC (default 2) cycles. The value stays unchanged while the strobe is high.
- R3: Op code 1 (write) raises the strobes in the order address capture, data capture, write. The address is on bus_val_o for the first phase and the write data for the other two. The target register then holds the write data.
- R4: Op code 0 (read; code 3 behaves the same) runs address capture and then the read strobe with bus_val_o at zero. bus_rdata_i is sampled while ack is high, and that value is on rdata_o when done_o pulses.
- R5: Op code 2 (read-modify-write) runs address capture, read, address capture, data capture, write. It writes (old & ~cmd_mask_i) | (cmd_wdata_i & cmd_mask_i) and reports the old value on rdata_o.
- R6: busy_o rises on the cycle after a command is accepted and falls together with a done or error pulse. A command presented while busy_o is high is ignored.
- R7: Each ack wait (for ack high and for ack low) has its own limit of TIMEOUT_CYC cycles. The count restarts at every wait, so a command whose total wait exceeds the limit still completes when no single wait exceeds it.
- R8: When a wait expires, err_o pulses instead of done_o. In the same cycle every strobe is low, bus_val_o is zero and busy_o is low.
- R9: At most one strobe is high in any cycle.
- R10: done_o and err_o are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present; taken when not busy |
| cmd_op_i | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| cmd_addr_i | input | 16 | Register address |
| cmd_wdata_i | input | 16 | Write data, or merge value for read-modify-write |
| cmd_mask_i | input | 16 | Merge mask for read-modify-write |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | One-cycle pulse on timeout abort |
| rdata_o | output | 16 | Register value read by the last read or read-modify-write |
| bus_val_o | output | 16 | Shared address/data value toward the peripheral |
| cap_addr_o | output | 1 | Address capture strobe |
| cap_data_o | output | 1 | Data capture strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| ack_i | input | 1 | Handshake acknowledge from the peripheral |
| bus_rdata_i | input | 16 | Register value returned by the peripheral |

## Verification
The bench builds the master with TIMEOUT_CYC set to 16 and SETUP_CYC left at 2. With that short limit, aborts caused by a missing ack or by an ack stuck high take about twenty cycles, so both can be observed exactly. The same limit lets a responder delay of 13 cycles per edge make each full command wait far longer than one limit while no single wait exceeds it. This shows that the count restarts at every wait.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_RMW = 2'd2} op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_WR, ST_RD} step_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_HI, PH_LO} ph_e;
endpackage

// File: rtl/cr_timer.sv
module cr_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cr_phase.sv
module cr_phase
  import cr_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 2,
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  output logic strobe_o,
  output logic hi_o,
  output logic done_o,
  output logic tmo_o
);
  localparam int unsigned SW = $clog2(SETUP_CYC + 1);

  ph_e           st_q;
  logic [SW-1:0] scnt_q;
  logic          waiting;

  assign waiting  = (st_q == PH_HI && !ack_i) || (st_q == PH_LO && ack_i);
  assign strobe_o = (st_q == PH_HI);
  assign hi_o     = (st_q == PH_HI) && ack_i;
  assign done_o   = (st_q == PH_LO) && !ack_i;

  cr_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!waiting),
    .en_i  (waiting),
    .hit_o (tmo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      scnt_q <= '0;
    end else begin
      case (st_q)
        PH_IDLE:  if (start_i) begin
                    st_q   <= PH_SETUP;
                    scnt_q <= '0;
                  end
        PH_SETUP: if (scnt_q == SW'(SETUP_CYC - 1)) st_q <= PH_HI;
                  else scnt_q <= scnt_q + 1'b1;
        PH_HI:    if (ack_i) st_q <= PH_LO;
                  else if (tmo_o) st_q <= PH_IDLE;
        PH_LO:    if (!ack_i || tmo_o) st_q <= PH_IDLE;
        default:  st_q <= PH_IDLE;
      endcase
    end
  end

  // R2
  strobe_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_o) |-> ($past(ack_i) || $past(tmo_o)));
  // R7
  tmo_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> (st_q == PH_IDLE));
endmodule

// File: rtl/cr_bus_master.sv
module cr_bus_master
  import cr_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned AW          = 16,
  parameter int unsigned SETUP_CYC   = 2,
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  input  logic [DW-1:0] cmd_mask_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] bus_val_o,
  output logic          cap_addr_o,
  output logic          cap_data_o,
  output logic          rd_o,
  output logic          wr_o,
  input  logic          ack_i,
  input  logic [DW-1:0] bus_rdata_i
);
  localparam int unsigned VW = (AW > DW) ? AW : DW;

  step_e         step_q;
  op_e           op_q;
  logic          wb_q, go_q, done_q, err_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wval_q, mask_q, rdata_q, merged;
  logic [VW-1:0] drv_q;
  logic          ph_strobe, ph_hi, ph_done, ph_tmo, accept;

  cr_phase #(.SETUP_CYC(SETUP_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (go_q),
    .ack_i   (ack_i),
    .strobe_o(ph_strobe),
    .hi_o    (ph_hi),
    .done_o  (ph_done),
    .tmo_o   (ph_tmo)
  );

  assign accept     = cmd_valid_i && (step_q == ST_IDLE);
  assign merged     = (rdata_q & ~mask_q) | (wval_q & mask_q);
  assign cap_addr_o = ph_strobe && (step_q == ST_ADDR);
  assign cap_data_o = ph_strobe && (step_q == ST_DATA);
  assign wr_o       = ph_strobe && (step_q == ST_WR);
  assign rd_o       = ph_strobe && (step_q == ST_RD);
  assign bus_val_o  = drv_q[DW-1:0];
  assign busy_o     = (step_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign rdata_o    = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE; op_q <= OP_READ; wb_q <= 1'b0; go_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; addr_q <= '0; wval_q <= '0;
      mask_q <= '0; rdata_q <= '0; drv_q <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        op_q   <= op_e'(cmd_op_i);
        addr_q <= cmd_addr_i;
        wval_q <= cmd_wdata_i;
        mask_q <= cmd_mask_i;
        wb_q   <= 1'b0;
        drv_q  <= VW'(cmd_addr_i);
        step_q <= ST_ADDR;
        go_q   <= 1'b1;
      end else if (ph_tmo) begin
        step_q <= ST_IDLE;
        drv_q  <= '0;
        err_q  <= 1'b1;
      end else begin
        if (ph_hi && step_q == ST_RD) rdata_q <= bus_rdata_i;
        if (ph_done) begin
          case (step_q)
            ST_ADDR: begin
              go_q <= 1'b1;
              if (op_q == OP_WRITE || wb_q) begin
                drv_q  <= VW'(wval_q);
                step_q <= ST_DATA;
              end else begin
                drv_q  <= '0;
                step_q <= ST_RD;
              end
            end
            ST_DATA: begin
              step_q <= ST_WR;
              go_q   <= 1'b1;
            end
            ST_WR: begin
              step_q <= ST_IDLE;
              drv_q  <= '0;
              done_q <= 1'b1;
            end
            ST_RD: begin
              if (op_q == OP_RMW) begin
                wb_q   <= 1'b1;
                wval_q <= merged;
                drv_q  <= VW'(addr_q);
                step_q <= ST_ADDR;
                go_q   <= 1'b1;
              end else begin
                step_q <= ST_IDLE;
                done_q <= 1'b1;
              end
            end
            default: step_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cap_addr_o, cap_data_o, rd_o, wr_o}));
  // R2
  val_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_addr_o || cap_data_o || rd_o || wr_o) |-> $stable(bus_val_o));
  // R4
  rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> (bus_val_o == '0));
  // R8
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && bus_val_o == '0 && !(cap_addr_o || cap_data_o || rd_o || wr_o)));
  // R10
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || err_o));
endmodule

// File: tb/test_cr_bus_master.sv
module test_cr_bus_master;
  localparam int TMO = 16;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = '0;
  logic [15:0] cmd_addr_i = '0, cmd_wdata_i = '0, cmd_mask_i = '0;
  logic        busy_o, done_o, err_o, cap_addr_o, cap_data_o, rd_o, wr_o;
  logic [15:0] rdata_o, bus_val_o;
  logic        ack_i;
  logic [15:0] bus_rdata_i;

  int n_run = 0, n_fail = 0;

  cr_bus_master #(.SETUP_CYC(2), .TIMEOUT_CYC(TMO)) i_cr_bus_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_addr_i(cmd_addr_i), .cmd_wdata_i(cmd_wdata_i), .cmd_mask_i(cmd_mask_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
    .bus_val_o(bus_val_o), .cap_addr_o(cap_addr_o), .cap_data_o(cap_data_o),
    .rd_o(rd_o), .wr_o(wr_o), .ack_i(ack_i), .bus_rdata_i(bus_rdata_i)
  );

  always #2 clk_i = ~clk_i;

  // responder model
  int          mode = 0;   // 0 normal, 1 never ack, 2 ack never falls
  int          dly = 2;
  logic        log_clr = 1'b0;
  logic [15:0] mem [16];
  logic [15:0] a_q, d_q, h1, h2;
  logic        prev_any;
  int          cnt, log_n, viol, multi;
  int          log_a [16];
  logic        any;
  assign any = cap_addr_o | cap_data_o | rd_o | wr_o;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_i <= 1'b0; bus_rdata_i <= '0; a_q <= '0; d_q <= '0; h1 <= '0; h2 <= '0;
      prev_any <= 1'b0; cnt <= 0; log_n <= 0; viol <= 0; multi <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      h1 <= bus_val_o; h2 <= h1; prev_any <= any;
      if (any && bus_val_o != h1) viol <= viol + 1;
      if (any && !prev_any && h1 != h2) viol <= viol + 1;
      if ($countones({cap_addr_o, cap_data_o, rd_o, wr_o}) > 1) multi <= multi + 1;
      if (log_clr) log_n <= 0;
      if (any && !ack_i) begin
        if (mode != 1) begin
          if (cnt >= dly - 1) begin
            ack_i <= 1'b1; cnt <= 0;
            if (!log_clr && log_n < 16) begin
              log_a[log_n] <= cap_addr_o ? 1 : cap_data_o ? 2 : rd_o ? 3 : 4;
              log_n <= log_n + 1;
            end
            if (cap_addr_o) a_q <= bus_val_o;
            if (cap_data_o) d_q <= bus_val_o;
            if (wr_o) mem[a_q[3:0]] <= d_q;
            if (rd_o) bus_rdata_i <= mem[a_q[3:0]];
          end else cnt <= cnt + 1;
        end
      end else if (!any && ack_i) begin
        if (mode != 2) begin
          if (cnt >= dly - 1) begin ack_i <= 1'b0; cnt <= 0; end
          else cnt <= cnt + 1;
        end
      end else cnt <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] a,
                       input logic [15:0] v, input logic [15:0] m);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a; cmd_wdata_i = v; cmd_mask_i = m;
    @(posedge clk_i); #1;
    cmd_valid_i = 1'b0;
  endtask

  task automatic wait_end(output int n, output bit d, output bit e, output logic [15:0] rd);
    n = 0; d = 0; e = 0; rd = '0;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk_i); #1; n++;
      if (done_o || err_o) begin d = done_o; e = err_o; rd = rdata_o; break; end
    end
  endtask

  task automatic clr_log();
    log_clr = 1'b1; @(posedge clk_i); #1; log_clr = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] v,
                       input logic [15:0] m, output int n, output bit d, output bit e,
                       output logic [15:0] rd);
    clr_log();
    issue(op, a, v, m);
    wait_end(n, d, e, rd);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !err_o, "R1", "status", {busy_o, done_o, err_o}, 0);
    chk(!any && bus_val_o == 0, "R1", "bus idle", {any, bus_val_o}, 0);
  endtask

  task automatic t_write();
    int n; bit d, e; logic [15:0] rd;
    do_op(2'd1, 16'h0003, 16'hBEEF, 16'h0, n, d, e, rd);
    chk(d && !e, "R3", "write done", {d, e}, 2);
    chk(log_n == 3 && log_a[0] == 1 && log_a[1] == 2 && log_a[2] == 4, "R3", "phase order",
        {log_a[0][7:0], log_a[1][7:0], log_a[2][7:0], log_n[7:0]}, 32'h01020403);
    chk(mem[3] == 16'hBEEF, "R3", "stored", mem[3], 16'hBEEF);
    chk(viol == 0, "R2", "setup/hold violations", viol, 0);
    @(posedge clk_i); #1;
    chk(!done_o, "R10", "done single cycle", done_o, 0);
  endtask

  task automatic t_read();
    int n; bit d, e; logic [15:0] rd;
    do_op(2'd0, 16'h0003, 16'h0, 16'h0, n, d, e, rd);
    chk(d && !e, "R4", "read done", {d, e}, 2);
    chk(log_n == 2 && log_a[0] == 1 && log_a[1] == 3, "R4", "phase order",
        {log_a[0][7:0], log_a[1][7:0], log_n[7:0]}, 32'h010302);
    chk(rd == 16'hBEEF, "R4", "read data", rd, 16'hBEEF);
  endtask

  task automatic t_rmw();
    int n; bit d, e; logic [15:0] rd;
    do_op(2'd2, 16'h0003, 16'h1234, 16'h00FF, n, d, e, rd);
    chk(d && !e, "R5", "rmw done", {d, e}, 2);
    chk(log_n == 5 && log_a[0] == 1 && log_a[1] == 3 && log_a[2] == 1 && log_a[3] == 2
        && log_a[4] == 4, "R5", "phase order", log_n, 5);
    chk(mem[3] == 16'hBE34, "R5", "merged", mem[3], 16'hBE34);
    chk(rd == 16'hBEEF, "R5", "old value", rd, 16'hBEEF);
    chk(viol == 0 && multi == 0, "R9", "strobe overlap/setup", {viol[15:0], multi[15:0]}, 0);
  endtask

  task automatic t_busy();
    int n; bit d, e; logic [15:0] rd;
    clr_log();
    issue(2'd1, 16'h0005, 16'h1111, 16'h0);
    chk(busy_o, "R6", "busy after accept", busy_o, 1);
    repeat (3) @(posedge clk_i);
    #1 issue(2'd1, 16'h0006, 16'h2222, 16'h0);
    wait_end(n, d, e, rd);
    chk(d && !busy_o, "R6", "busy falls with done", {d, busy_o}, 2);
    repeat (4) @(posedge clk_i); #1;
    chk(!busy_o && log_n == 3, "R6", "second command ignored", {busy_o, log_n[7:0]}, 3);
    do_op(2'd0, 16'h0006, 16'h0, 16'h0, n, d, e, rd);
    chk(rd == 16'h0000, "R6", "reg 6 untouched", rd, 0);
  endtask

  task automatic t_no_ack();
    int n; bit d, e; logic [15:0] rd;
    mode = 1;
    do_op(2'd1, 16'h0007, 16'h5555, 16'h0, n, d, e, rd);
    chk(e && !d, "R8", "error not done", {d, e}, 1);
    chk(n >= TMO && n <= TMO + 4, "R7", "abort latency", n, TMO + 3);
    chk(!busy_o && bus_val_o == 0 && !any, "R8", "bus idle on abort", {busy_o, any, bus_val_o}, 0);
    mode = 0;
    repeat (4) @(posedge clk_i); #1;
  endtask

  task automatic t_stuck();
    int n; bit d, e; logic [15:0] rd;
    mode = 2;
    do_op(2'd0, 16'h0003, 16'h0, 16'h0, n, d, e, rd);
    chk(e && !d, "R7", "stuck ack aborts", {d, e}, 1);
    chk(!busy_o && !any && bus_val_o == 0, "R8", "idle after stuck", {busy_o, any, bus_val_o}, 0);
    mode = 0;
    repeat (6) @(posedge clk_i); #1;
    do_op(2'd0, 16'h0003, 16'h0, 16'h0, n, d, e, rd);
    chk(d && rd == 16'hBE34, "R8", "recovery read", rd, 16'hBE34);
  endtask

  task automatic t_slow();
    int n; bit d, e; logic [15:0] rd;
    dly = TMO - 3;
    do_op(2'd1, 16'h0009, 16'hA5A5, 16'h0, n, d, e, rd);
    chk(d && !e, "R7", "slow ack per wait ok", {d, e}, 2);
    chk(n > 3 * TMO, "R7", "total wait beyond limit", n, 3 * TMO);
    chk(mem[9] == 16'hA5A5, "R7", "slow write stored", mem[9], 16'hA5A5);
    dly = 2;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 t_reset();
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_write();
    t_read();
    t_rmw();
    t_busy();
    t_no_ack();
    t_stuck();
    t_slow();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule